// File: doc/BRIEF.md
# Machine-Cycle State Sequencer

This block derives the internal timing frame of a small microcontroller core from its oscillator clock. A machine cycle has six states, S1 to S6, taken in order. Each state lasts two oscillator periods, a first and a second phase, so one machine cycle takes twelve clocks. An instruction takes one, two or four machine cycles. The instruction decoder gives that length as a two-bit code.

In each state the block raises a fixed set of single-clock action enables, which the datapath uses. The slots are the same from one cycle to the next. Program memory is fetched twice in every machine cycle, whether or not the instruction uses the bytes. The first machine cycle moves the accumulator to a temporary register and reads data RAM. Every later machine cycle instead forms the jump target and increments the program counter. Every machine cycle ends with an operand latch and an ALU write-back. One clock after an instruction finishes, the next instruction begins.

Top module: `mcycle_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the block in S1 (`state_oh` = 6'b000001), first phase (`phase` = 0), machine cycle 0 (`mcyc` = 0). The state is the same on the clock after `rst` falls.
- R2: `phase` toggles on every clock. `state_oh` is one-hot, with bit k for state S(k+1). It moves one state ahead after each second phase, and wraps from S6 to S1.
- R3: `cyc_sel` is sampled only in the clock of S1, first phase, machine cycle 0. The codes are 2'b00 = 1 machine cycle, 2'b01 = 2, and 2'b10 or 2'b11 = 4. Values present at any other clock have no effect on the instruction length.
- R4: `mcyc` counts the machine cycles of the current instruction from 0 to n-1. It advances when S6 moves to S1.
- R5: `fetch_stb` is high during the first phase of S1 and of S4 in every machine cycle, which gives exactly two fetch pulses per machine cycle.
- R6: In machine cycle 0 only, `acc_to_tmp` is high in the second phase of S2 and `ram_acc` is high in the second phase of S3.
- R7: In every machine cycle after the first, `jmp_calc` is high in the second phase of S2 and `pc_inc` is high in the second phase of S3.
- R8: In every machine cycle, `opnd_lat` is high in the second phase of S5 and `alu_wb` is high in the second phase of S6.
- R9: `instr_done` is high for exactly one clock, the second phase of S6 in the last machine cycle. The next clock is S1, first phase, machine cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_sel | input | 2 | Instruction length code from decode |
| state_oh | output | 6 | One-hot current state, bit 0 = S1 |
| phase | output | 1 | 0 = first period of the state, 1 = second |
| mcyc | output | 2 | Machine cycle index within the instruction |
| fetch_stb | output | 1 | Program memory fetch enable |
| acc_to_tmp | output | 1 | Accumulator-to-temp copy enable |
| ram_acc | output | 1 | Data RAM access enable |
| jmp_calc | output | 1 | Jump target calculation enable |
| pc_inc | output | 1 | Program counter increment enable |
| opnd_lat | output | 1 | Operand-to-temp latch enable |
| alu_wb | output | 1 | ALU result write-back enable |
| instr_done | output | 1 | Last clock of the instruction |

## Verification
The embedded assertions check the following on every clock:
- the one-hot state and the toggling phase;
- a state change only at a second phase, with the wrap from S6 to S1;
- fetch pulses only in their two slots;
- the machine-cycle index never passing the captured length;
- the restart after `instr_done`.

Some properties are shown only by the bench scenarios:
- the length that each `cyc_sel` code selects;
- that `cyc_sel` is ignored outside the sampling clock;
- the split between first-cycle actions and later-cycle actions;
- the exact clock of `instr_done`.

For these, the bench sweeps all four codes and drives conflicting values on `cyc_sel` during the rest of each instruction.

// File: rtl/mcycle_seq.sv
module mcycle_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cyc_sel,
  output logic [5:0] state_oh,
  output logic       phase,
  output logic [1:0] mcyc,
  output logic       fetch_stb,
  output logic       acc_to_tmp,
  output logic       ram_acc,
  output logic       jmp_calc,
  output logic       pc_inc,
  output logic       opnd_lat,
  output logic       alu_wb,
  output logic       instr_done
);

  localparam int NST = 6;
  localparam int MCW = 2;

  logic [NST-1:0] st_q;
  logic           ph_q;
  logic [MCW-1:0] mc_q;
  logic [MCW-1:0] last_q;
  logic [MCW-1:0] sel_last;

  wire first_clk = st_q[0] & ~ph_q & (mc_q == '0);
  wire end_mc    = st_q[NST-1] & ph_q;
  wire first_mc  = (mc_q == '0);

  always_comb begin
    case (cyc_sel)
      2'b00:   sel_last = 2'd0;
      2'b01:   sel_last = 2'd1;
      default: sel_last = 2'd3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= NST'(1);
      ph_q   <= 1'b0;
      mc_q   <= '0;
      last_q <= '0;
    end else begin
      ph_q <= ~ph_q;
      if (ph_q) st_q <= {st_q[NST-2:0], st_q[NST-1]};
      if (first_clk) last_q <= sel_last;
      if (end_mc) mc_q <= (mc_q == last_q) ? '0 : MCW'(mc_q + 1'b1);
    end
  end

  assign state_oh   = st_q;
  assign phase      = ph_q;
  assign mcyc       = mc_q;
  assign fetch_stb  = (st_q[0] | st_q[3]) & ~ph_q;
  assign acc_to_tmp = first_mc & st_q[1] & ph_q;
  assign ram_acc    = first_mc & st_q[2] & ph_q;
  assign jmp_calc   = ~first_mc & st_q[1] & ph_q;
  assign pc_inc     = ~first_mc & st_q[2] & ph_q;
  assign opnd_lat   = st_q[4] & ph_q;
  assign alu_wb     = end_mc;
  assign instr_done = end_mc & (mc_q == last_q);

  // R2
  state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(state_oh) == 1);

  // R2
  phase_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !phase |=> phase);

  // R2
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !phase |=> $stable(state_oh));

  // R2
  state_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (phase && state_oh[5]) |=> state_oh[0]);

  // R5
  fetch_slot_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_stb |-> (!phase && (state_oh[0] || state_oh[3])));

  // R4
  mcyc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    mc_q <= last_q);

  // R9
  done_restart_chk: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> (state_oh[0] && !phase && mcyc == 2'd0));

  // R9
  done_slot_chk: assert property (@(posedge clk) disable iff (rst)
    instr_done |-> (state_oh[5] && phase));

endmodule

// File: tb/mcycle_seq_bench.sv
module mcycle_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cyc_sel = 2'b00;
  logic [5:0] state_oh;
  logic       phase;
  logic [1:0] mcyc;
  logic fetch_stb, acc_to_tmp, ram_acc, jmp_calc, pc_inc, opnd_lat, alu_wb, instr_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  mcycle_seq u_mcycle_seq (
    .clk(clk), .rst(rst), .cyc_sel(cyc_sel), .state_oh(state_oh), .phase(phase),
    .mcyc(mcyc), .fetch_stb(fetch_stb), .acc_to_tmp(acc_to_tmp), .ram_acc(ram_acc),
    .jmp_calc(jmp_calc), .pc_inc(pc_inc), .opnd_lat(opnd_lat), .alu_wb(alu_wb),
    .instr_done(instr_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_reset_state(input string tag);
    chk(tag, {23'd0, state_oh, phase, mcyc}, {23'd0, 6'b000001, 1'b0, 2'd0});
  endtask

  task automatic run_instr(input logic [1:0] s, input logic [1:0] junk);
    int n = (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
    int fcnt = 0;
    for (int p = 0; p < 12 * n; p++) begin
      int st = (p / 2) % 6;
      int ph = p % 2;
      int mc = p / 12;
      logic [7:0] exp_s;
      exp_s[7] = (st == 0 || st == 3) && ph == 0;
      exp_s[6] = mc == 0 && st == 1 && ph == 1;
      exp_s[5] = mc == 0 && st == 2 && ph == 1;
      exp_s[4] = mc != 0 && st == 1 && ph == 1;
      exp_s[3] = mc != 0 && st == 2 && ph == 1;
      exp_s[2] = st == 4 && ph == 1;
      exp_s[1] = st == 5 && ph == 1;
      exp_s[0] = p == 12 * n - 1;
      // R2 R4 state, phase and machine cycle index
      chk("R2 R4 state/phase/mcyc", {23'd0, state_oh, phase, mcyc},
          {23'd0, 6'(1 << st), 1'(ph), 2'(mc)});
      // R3 R5 R6 R7 R8 R9 strobe slots and done position
      chk("R3 R5 R6 R7 R8 R9 strobes",
          {24'd0, fetch_stb, acc_to_tmp, ram_acc, jmp_calc, pc_inc, opnd_lat, alu_wb, instr_done},
          {24'd0, exp_s});
      if (fetch_stb) fcnt++;
      if (st == 5 && ph == 1) begin
        // R5 two fetches per machine cycle
        chk("R5 fetch count", 32'(fcnt), 32'd2);
        fcnt = 0;
      end
      cyc_sel = (p == 0) ? s : junk;
      @(negedge clk);
    end
  endtask

  initial begin
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_reset_state("R1 reset");
    rst = 1'b0;
    for (int s = 0; s < 4; s++) begin
      run_instr(2'(s), 2'(s + 1));
      run_instr(2'(s), 2'(s) ^ 2'b11);
    end
    run_instr(2'b00, 2'b10);
    run_instr(2'b10, 2'b00);
    run_instr(2'b01, 2'b00);
    cyc_sel = 2'b10;
    repeat (19) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    // R1 reset in the middle of an instruction
    chk_reset_state("R1 mid reset");
    rst = 1'b0;
    run_instr(2'b01, 2'b10);
    run_instr(2'b11, 2'b00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule